// File: doc/BRIEF.md
# Signed-Count Register Shifter

This block shifts a 64-bit register value by a count taken from a core register or an immediate field. The count is read as a small signed number: a zero or positive value shifts left with zero fill, and a negative value shifts right arithmetically, so the vacated bits take copies of the sign bit. Only the lowest six bits of the count word are used. Because of this, a count outside the range -32 to +31 wraps silently. For example, a request to shift left by 48 becomes an arithmetic right shift by 16.

The block has two operand modes. In full mode all 64 bits take part in the shift. In word mode only the low 32 bits of the operand are shifted. The 32-bit result goes in the low half of the output, and the high half is filled with copies of result bit 31. Each request comes with a valid strobe. The result is registered and appears one cycle later, together with a one-cycle valid pulse. Between pulses the last result is held.

Top module: `shf_signed_shifter`

## Requirements
- R1: While rst_n is low, and in the first cycle after it, out_valid is 0 and out_result is all zeros.
- R2: out_valid is 1 exactly in the cycle after a cycle with in_valid high. out_result changes only on such a cycle and holds its value otherwise.
- R3: The effective count is in_count[5:0] read as a two's-complement value in the range -32..+31. Bits above bit 5 of in_count have no effect on the result.
- R4: An effective count k from 0 to 31 shifts the operand left by k and fills the low bits with zeros.
- R5: In full mode (in_word_mode = 0), an effective count of -1 to -32 shifts all 64 operand bits right by the magnitude of the count and fills with operand bit 63.
- R6: An in_count of 48 (low six bits 110000) gives an arithmetic right shift by 16.
- R7: In word mode (in_word_mode = 1), only in_operand[31:0] is shifted, using 32-bit left or arithmetic-right rules. out_result[63:32] equals 32 copies of out_result[31]. in_operand[63:32] has no effect on the result.
- R8: In word mode, an effective count of -32 gives a result whose 64 bits are all equal to in_operand[31].
- R9: In full mode, an effective count of 0 gives out_result equal to in_operand, bit for bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request strobe, one cycle per request |
| in_word_mode | input | 1 | 1 = 32-bit word mode, 0 = full 64-bit mode |
| in_operand | input | 64 | Value to shift |
| in_count | input | 32 | Count word; only bits [5:0] are used, as a signed value |
| out_valid | output | 1 | Result pulse, one cycle after in_valid |
| out_result | output | 64 | Registered shifted value |

## Verification
The bench builds the block with its default parameters: a 64-bit operand and a 32-bit count word. With these values the width of the count word is much larger than the six bits that are used, so the truncation of the count (including the wrap of 48 and of words with their high bits set) is exercised directly. All 64 values of the six-bit field are applied in both modes against a reference that shifts one bit at a time. This covers both ends of the range, +31 and -32, and the word-mode case where the result is all sign bits.

// File: rtl/shf_pkg.sv
package shf_pkg;

  localparam int unsigned SHF_FIELD_W = 6;
  localparam int unsigned SHF_AMT_W   = 6;

  typedef struct packed {
    logic                 go_left;
    logic [SHF_AMT_W-1:0] amount;
  } shf_cnt_t;

  // Signed six-bit field -> direction and magnitude (0..32)
  function automatic shf_cnt_t shf_decode(input logic [SHF_FIELD_W-1:0] fld);
    shf_cnt_t d;
    d.go_left = ~fld[SHF_FIELD_W-1];
    if (d.go_left) d.amount = fld;
    else           d.amount = SHF_AMT_W'(-fld);
    return d;
  endfunction

endpackage

// File: rtl/shf_count_decode.sv
module shf_count_decode
  import shf_pkg::*;
(
  input  logic [SHF_FIELD_W-1:0] count_field,
  output shf_cnt_t               dec
);

  always_comb dec = shf_decode(count_field);

endmodule

// File: rtl/shf_core.sv
module shf_core
  import shf_pkg::*;
#(
  parameter int unsigned DATA_W = 64
) (
  input  logic [DATA_W-1:0] operand,
  input  logic              word_mode,
  input  shf_cnt_t          dec,
  output logic [DATA_W-1:0] result
);

  localparam int unsigned HALF_W = DATA_W / 2;

  function automatic logic [DATA_W-1:0] full_shift(input logic [DATA_W-1:0] v,
                                                    input shf_cnt_t d);
    if (d.go_left) return v << d.amount;
    else           return DATA_W'($signed(v) >>> d.amount);
  endfunction

  function automatic logic [HALF_W-1:0] half_shift(input logic [HALF_W-1:0] v,
                                                    input shf_cnt_t d);
    logic [DATA_W-1:0] wide;
    wide = {{HALF_W{v[HALF_W-1]}}, v};
    if (d.go_left) return v << d.amount;
    else           return HALF_W'($signed(wide) >>> d.amount);
  endfunction

  logic [DATA_W-1:0] full_res;
  logic [HALF_W-1:0] half_res;

  always_comb begin
    full_res = full_shift(operand, dec);
    half_res = half_shift(operand[HALF_W-1:0], dec);
    if (word_mode) result = {{HALF_W{half_res[HALF_W-1]}}, half_res};
    else           result = full_res;
  end

endmodule

// File: rtl/shf_signed_shifter.sv
module shf_signed_shifter
  import shf_pkg::*;
#(
  parameter int unsigned DATA_W   = 64,
  parameter int unsigned CNT_IN_W = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                in_valid,
  input  logic                in_word_mode,
  input  logic [DATA_W-1:0]   in_operand,
  input  logic [CNT_IN_W-1:0] in_count,
  output logic                out_valid,
  output logic [DATA_W-1:0]   out_result
);

  localparam int unsigned HALF_W = DATA_W / 2;

  // Named internal events for the checks below
  logic [SHF_FIELD_W-1:0] count_field;
  shf_cnt_t               dec;
  logic [DATA_W-1:0]      core_result;
  logic                   take_req;

  assign count_field = in_count[SHF_FIELD_W-1:0];
  assign take_req    = in_valid;

  shf_count_decode u_dec (
    .count_field (count_field),
    .dec         (dec)
  );

  shf_core #(.DATA_W(DATA_W)) u_core (
    .operand   (in_operand),
    .word_mode (in_word_mode),
    .dec       (dec),
    .result    (core_result)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid  <= 1'b0;
      out_result <= '0;
    end else begin
      out_valid <= take_req;
      if (take_req) out_result <= core_result;
    end
  end

  AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid); // R2
  AST_NO_SPURIOUS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid); // R2
  AST_RESULT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(out_result)); // R2
  AST_WORD_SEXT: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_word_mode) |=> out_result[DATA_W-1:HALF_W] == {HALF_W{out_result[HALF_W-1]}}); // R7
  AST_ZERO_COPY: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !in_word_mode && count_field == '0) |=> out_result == $past(in_operand)); // R9
  AST_RIGHT_KEEPS_SIGN: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !in_word_mode && count_field[SHF_FIELD_W-1]) |=>
      out_result[DATA_W-1] == $past(in_operand[DATA_W-1])); // R5
  AST_WORD_MIN_ALL_SIGN: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_word_mode && count_field == 6'b100000) |=>
      out_result == {DATA_W{$past(in_operand[HALF_W-1])}}); // R8

endmodule

// File: tb/shf_signed_shifter_tb_top.sv
module shf_signed_shifter_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_word_mode = 1'b0;
  logic [63:0] in_operand = '0;
  logic [31:0] in_count = '0;
  logic        out_valid;
  logic [63:0] out_result;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  shf_signed_shifter dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_word_mode(in_word_mode),
    .in_operand(in_operand), .in_count(in_count),
    .out_valid(out_valid), .out_result(out_result)
  );

  // Bit-serial reference
  function automatic logic [63:0] ref_shift(input logic [63:0] op,
                                            input logic [31:0] cnt, input bit word);
    int k;
    logic [31:0] w;
    logic [63:0] f;
    k = cnt[5] ? int'(cnt[5:0]) - 64 : int'(cnt[5:0]);
    if (word) begin
      w = op[31:0];
      if (k >= 0) for (int i = 0; i < k; i++) w = {w[30:0], 1'b0};
      else        for (int i = 0; i < -k; i++) w = {w[31], w[31:1]};
      return {{32{w[31]}}, w};
    end
    f = op;
    if (k >= 0) for (int i = 0; i < k; i++) f = {f[62:0], 1'b0};
    else        for (int i = 0; i < -k; i++) f = {f[63], f[63:1]};
    return f;
  endfunction

  task automatic check64(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // One request; result sampled at the negedge after the capturing edge
  task automatic run_op(input string req, input logic [63:0] op,
                        input logic [31:0] cnt, input bit word, input logic [63:0] exp);
    @(negedge clk);
    in_valid = 1'b1; in_operand = op; in_count = cnt; in_word_mode = word;
    @(negedge clk);
    in_valid = 1'b0; in_operand = ~op; in_count = ~cnt;
    check64({req, " valid"}, {63'd0, out_valid}, 64'd1);
    check64(req, out_result, exp);
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check64("R1 valid", {63'd0, out_valid}, 64'd0);
    check64("R1 result", out_result, 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check64("R1 valid after", {63'd0, out_valid}, 64'd0);
    check64("R1 result after", out_result, 64'd0);
  endtask

  task automatic t_left();
    run_op("R4 k=1", 64'h8000_0000_0000_0001, 32'd1, 1'b0, 64'h2);
    run_op("R4 k=31", 64'h0000_0000_0000_0003, 32'd31, 1'b0, 64'h1_8000_0000);
    run_op("R4 k=4 word", 64'h0, 32'd4, 1'b1, 64'h0);
  endtask

  task automatic t_right();
    run_op("R5 k=-1", 64'h8000_0000_0000_0000, 32'h3F, 1'b0, 64'hC000_0000_0000_0000);
    run_op("R5 k=-32", 64'h8765_4321_0000_0000, 32'h20, 1'b0, 64'hFFFF_FFFF_8765_4321);
    run_op("R5 k=-4 pos", 64'h7000_0000_0000_0000, 32'hFFFF_FFFC, 1'b0, 64'h0700_0000_0000_0000);
  endtask

  task automatic t_wrap();
    run_op("R6 cnt=48", 64'h8000_0000_0000_0000, 32'd48, 1'b0, 64'hFFFF_8000_0000_0000);
    run_op("R3 high bits", 64'h1, 32'hFFFF_FF81, 1'b0, 64'h2);
    run_op("R3 cnt=64", 64'h1234_5678_9ABC_DEF0, 32'd64, 1'b0, 64'h1234_5678_9ABC_DEF0);
  endtask

  task automatic t_word();
    run_op("R7 upper ignored", 64'hDEAD_BEEF_4000_0001, 32'd1, 1'b1, 64'hFFFF_FFFF_8000_0002);
    run_op("R7 right", 64'h1111_1111_8000_0000, 32'h3C, 1'b1, 64'hFFFF_FFFF_F800_0000);
    run_op("R8 -32 neg", 64'h0000_0000_8000_0000, 32'h20, 1'b1, 64'hFFFF_FFFF_FFFF_FFFF);
    run_op("R8 -32 pos", 64'hFFFF_FFFF_7FFF_FFFF, 32'h20, 1'b1, 64'h0);
  endtask

  task automatic t_copy();
    run_op("R9 zero copy", 64'hF0E1_D2C3_B4A5_9687, 32'd0, 1'b0, 64'hF0E1_D2C3_B4A5_9687);
  endtask

  task automatic t_hold();
    logic [63:0] kept;
    run_op("R2 op", 64'h55, 32'd2, 1'b0, 64'h154);
    kept = out_result;
    @(negedge clk);
    check64("R2 pulse ends", {63'd0, out_valid}, 64'd0);
    in_operand = 64'hFFFF; in_count = 32'd3;
    @(negedge clk);
    check64("R2 hold", out_result, kept);
  endtask

  task automatic t_sweep();
    for (int m = 0; m < 2; m++) begin
      for (int c = 0; c < 64; c++) begin
        logic [63:0] op;
        logic [31:0] cnt;
        op  = {$urandom, $urandom};
        cnt = {$urandom, 26'd0} | 32'(c);
        run_op(m ? "R3 R7 sweep" : "R3 R4 R5 sweep", op, cnt, m[0], ref_shift(op, cnt, m[0]));
      end
    end
  endtask

  initial begin
    t_reset();
    t_left();
    t_right();
    t_wrap();
    t_word();
    t_copy();
    t_hold();
    t_sweep();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

endmodule